// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block lets a simple read bus see a 64 MiB span of serial flash as ordinary memory. A bus read carries a 32-bit word offset into the window. The block forms a flash byte address from that offset and from a separate extended-address field. It then runs a serial read frame on a one-bit-per-clock flash bus. The frame has an optional opcode, address, option byte and dummy cycles, followed by the data. A small line buffer keeps the words that come back, so later reads that fall inside the fetched line are answered straight away without touching the flash.

Software sets up the frame (opcode, address width, option byte, dummy count, which phases are present), the burst length and the extended-address bits, and then clears the mode bit so that bus reads are served. A flush pulse discards the buffered line after the flash contents have changed. While the mode bit is set, the serial bus belongs to the manual sequencer, and bus reads are refused with an error response. Writes and double-data-rate phases are not supported.

Top module: `flash_read_window`

## Requirements
- R1: The flash byte address is the bus word offset times four, ORed with the extended-address field shifted to bit 25. Bus offset bit 25 (word bit 23) therefore aliases extended bit 0.
- R2: A frame asserts `fl_sel` and sends one bit per clock. Its phases come in the fixed order opcode (8 bits, MSB first, when enabled), address (24 low bits, or 32 bits when `cfg_addr4` is set, MSB first, when enabled), option (8 bits, MSB first, when enabled), dummy (`cfg_dummy` cycles, none when zero), then data. `fl_phase` reads 0 idle, 1 opcode, 2 address, 3 option, 4 dummy, 5 data.
- R3: Each data byte arrives MSB first. The first byte of a word fills bits 7:0 and the fourth fills bits 31:24.
- R4: With bursting enabled, a miss fetches L = `cfg_burst_m1`+1 words. The fetch starts at the requested word index rounded down to a multiple of the largest power of two not above L. The response comes only after the whole burst.
- R5: With bursting enabled, a read that falls inside the valid line is answered in the cycle after acceptance, with no frame on the flash bus.
- R6: A one-cycle `cfg_flush` pulse invalidates the line, so the next read starts a new frame.
- R7: The line tag covers the extended-address bits, so changing `cfg_ext` turns a previously buffered offset into a miss.
- R8: With bursting disabled, every read fetches exactly one word and is never served from the buffer.
- R9: While `cfg_manual` is 1, an accepted read gets `rd_resp_err`=1 and data 0 in the next cycle, and no frame is started.
- R10: `rd_ready` is low from the acceptance of a miss until its response, and every accepted read gets exactly one response.
- R11: After reset `fl_sel` is low, `fl_phase` is 0, `rd_ready` is high, no response is pending and the line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_manual | input | 1 | 1: manual sequencer owns the flash; 0: window reads served |
| cfg_cmd_en | input | 1 | Opcode phase present |
| cfg_cmd | input | 8 | Read opcode |
| cfg_addr_en | input | 1 | Address phase present |
| cfg_addr4 | input | 1 | 32-bit address phase when 1, 24-bit when 0 |
| cfg_opt_en | input | 1 | Option phase present |
| cfg_opt | input | 8 | Option byte |
| cfg_dummy | input | 5 | Dummy cycle count |
| cfg_burst_en | input | 1 | Enable buffered bursting |
| cfg_burst_m1 | input | BLEN_BITS | Burst length in words minus one |
| cfg_ext | input | EXT_BITS | Flash address bits from bit 25 upward |
| cfg_flush | input | 1 | One-cycle line invalidate |
| rd_valid | input | 1 | Read request |
| rd_word | input | WIN_BITS-2 | Word offset inside the window |
| rd_ready | output | 1 | Request accepted when high with rd_valid |
| rd_resp_valid | output | 1 | Response strobe |
| rd_resp_data | output | 32 | Read data |
| rd_resp_err | output | 1 | Error response (manual mode) |
| fl_sel | output | 1 | Flash select, high during a frame |
| fl_phase | output | 3 | Current frame phase |
| fl_mosi | output | 1 | Serial bit to flash |
| fl_miso | input | 1 | Serial bit from flash, sampled in data phase |

## Verification
The assertions check some rules on every cycle. Phases inside one frame only move forward. Any read accepted in manual mode gets an error response one cycle later, and the flash bus stays idle during that response. The bus is never ready while a frame runs, and the reset state is checked too. Other behaviour only shows up when the bench's flash model replays whole scenarios. That covers the exact bits on the flash bus and the address arithmetic, including extended-bit aliasing, burst alignment for lengths that are not powers of two, the byte order of the data, and the effects of flush, extended-address changes and disabled bursting on hits and misses.

// File: rtl/frw_pkg.sv
package frw_pkg;

    localparam int unsigned WIN_BITS_D  = 26;
    localparam int unsigned EXT_BITS_D  = 4;
    localparam int unsigned BLEN_BITS_D = 5;
    localparam int unsigned WORD_W      = 32;

    // Phase codes are visible on the flash bus; their order is the frame order.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_OPT   = 3'd3,
        PH_DUMMY = 3'd4,
        PH_DATA  = 3'd5
    } phase_e;

    typedef enum logic {
        CT_IDLE = 1'b0,
        CT_FILL = 1'b1
    } ctl_e;

    typedef struct packed {
        logic       cmd_en;
        logic [7:0] cmd;
        logic       addr_en;
        logic       addr4;
        logic       opt_en;
        logic [7:0] opt;
        logic [4:0] dummy;
    } frame_t;

    function automatic logic phase_on(phase_e p, frame_t f);
        case (p)
            PH_CMD:   return f.cmd_en;
            PH_ADDR:  return f.addr_en;
            PH_OPT:   return f.opt_en;
            PH_DUMMY: return f.dummy != 5'd0;
            PH_DATA:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    // First enabled phase strictly after p; data is always present.
    function automatic phase_e phase_after(phase_e p, frame_t f);
        phase_e r;
        r = PH_DATA;
        for (int i = 5; i >= 1; i--) begin
            if (i > int'(p) && phase_on(phase_e'(3'(i)), f)) r = phase_e'(3'(i));
        end
        return r;
    endfunction

    // Largest power of two not above n (n >= 1).
    function automatic int unsigned pow2_floor(int unsigned n);
        int unsigned r;
        r = 1;
        for (int i = 0; i < 31; i++) begin
            if ((32'd1 << i) <= n) r = 32'd1 << i;
        end
        return r;
    endfunction

endpackage

// File: rtl/frw_seq.sv
module frw_seq
    import frw_pkg::*;
#(
    parameter int unsigned LINE_WORDS = 32,
    parameter int unsigned WA_W       = 27
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  frame_t                             frame,
    input  logic [WA_W-1:0]                    waddr,
    input  logic [$clog2(LINE_WORDS):0]        nwords,
    output logic                               done,
    output logic                               wr_en,
    output logic [$clog2(LINE_WORDS)-1:0]      wr_idx,
    output logic [WORD_W-1:0]                  wr_data,
    output logic                               fl_sel,
    output logic [2:0]                         fl_phase,
    output logic                               fl_mosi,
    input  logic                               fl_miso
);
    localparam int unsigned IDX_W = $clog2(LINE_WORDS);
    localparam int unsigned LEN_W = IDX_W + 1;
    localparam int unsigned WB    = $clog2(WORD_W);
    localparam int unsigned CNT_W = IDX_W + WB + 1;

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    frame_t            frame_q;
    logic [WA_W-1:0]   addr_q;
    logic [LEN_W-1:0]  nw_q;
    logic [6:0]        sh_q;
    logic [23:0]       acc_q;
    logic              done_q;
    logic [CNT_W-1:0]  last_cnt;
    logic [31:0]       addr_bytes;

    assign addr_bytes = 32'({addr_q, 2'b00});

    always_comb begin
        case (phase_q)
            PH_CMD:   last_cnt = CNT_W'(7);
            PH_ADDR:  last_cnt = frame_q.addr4 ? CNT_W'(31) : CNT_W'(23);
            PH_OPT:   last_cnt = CNT_W'(7);
            PH_DUMMY: last_cnt = CNT_W'(frame_q.dummy) - CNT_W'(1);
            PH_DATA:  last_cnt = (CNT_W'(nw_q) << WB) - CNT_W'(1);
            default:  last_cnt = '0;
        endcase
    end

    always_comb begin
        fl_mosi = 1'b0;
        case (phase_q)
            PH_CMD:  fl_mosi = frame_q.cmd[3'(~cnt_q[2:0])];
            PH_ADDR: fl_mosi = frame_q.addr4 ? addr_bytes[5'(~cnt_q[4:0])]
                                             : addr_bytes[5'(5'd23 - cnt_q[4:0])];
            PH_OPT:  fl_mosi = frame_q.opt[3'(~cnt_q[2:0])];
            default: fl_mosi = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            frame_q <= '0;
            addr_q  <= '0;
            nw_q    <= '0;
            sh_q    <= '0;
            acc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                phase_q <= phase_after(PH_IDLE, frame);
                cnt_q   <= '0;
                frame_q <= frame;
                addr_q  <= waddr;
                nw_q    <= nwords;
            end else if (phase_q != PH_IDLE) begin
                if (cnt_q == last_cnt) begin
                    cnt_q <= '0;
                    if (phase_q == PH_DATA) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= phase_after(phase_q, frame_q);
                    end
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (phase_q == PH_DATA) begin
                    if (cnt_q[2:0] == 3'd7) begin
                        if (cnt_q[4:3] != 2'd3)
                            acc_q[{cnt_q[4:3], 3'b000} +: 8] <= {sh_q, fl_miso};
                    end else begin
                        sh_q <= {sh_q[5:0], fl_miso};
                    end
                end
            end
        end
    end

    // The last bit of each word completes lane 3 directly from the pin.
    assign wr_en    = (phase_q == PH_DATA) && (cnt_q[4:0] == 5'd31);
    assign wr_idx   = cnt_q[WB +: IDX_W];
    assign wr_data  = {sh_q, fl_miso, acc_q};
    assign done     = done_q;
    assign fl_sel   = phase_q != PH_IDLE;
    assign fl_phase = phase_q;

endmodule

// File: rtl/frw_line.sv
module frw_line
    import frw_pkg::*;
#(
    parameter int unsigned LINE_WORDS = 32,
    parameter int unsigned WA_W       = 27
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           fill_start,
    input  logic [WA_W-1:0]                fill_base,
    input  logic [$clog2(LINE_WORDS):0]    fill_len,
    input  logic                           fill_done,
    input  logic                           fill_keep,
    input  logic                           wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0]  wr_idx,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [WA_W-1:0]                look_addr,
    output logic                           hit,
    output logic [WORD_W-1:0]              look_data
);
    localparam int unsigned IDX_W = $clog2(LINE_WORDS);
    localparam int unsigned LEN_W = IDX_W + 1;

    logic [WORD_W-1:0] mem_q [LINE_WORDS];
    logic [WA_W-1:0]   base_q;
    logic [LEN_W-1:0]  len_q;
    logic              valid_q;
    logic              kill_q;
    logic [WA_W-1:0]   diff;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            len_q   <= '0;
            valid_q <= 1'b0;
            kill_q  <= 1'b0;
        end else begin
            if (fill_start) begin
                valid_q <= 1'b0;
                base_q  <= fill_base;
                len_q   <= fill_len;
                kill_q  <= 1'b0;
            end else if (fill_done) begin
                valid_q <= fill_keep && !kill_q;
            end
            // A flush during a fill keeps the fetched line from becoming valid.
            if (flush) begin
                valid_q <= 1'b0;
                kill_q  <= 1'b1;
            end
        end
    end

    assign diff      = look_addr - base_q;
    assign hit       = valid_q && (diff < WA_W'(len_q));
    assign look_data = mem_q[diff[IDX_W-1:0]];

endmodule

// File: rtl/flash_read_window.sv
module flash_read_window
    import frw_pkg::*;
#(
    parameter int unsigned WIN_BITS  = WIN_BITS_D,
    parameter int unsigned EXT_BITS  = EXT_BITS_D,
    parameter int unsigned BLEN_BITS = BLEN_BITS_D
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_manual,
    input  logic                  cfg_cmd_en,
    input  logic [7:0]            cfg_cmd,
    input  logic                  cfg_addr_en,
    input  logic                  cfg_addr4,
    input  logic                  cfg_opt_en,
    input  logic [7:0]            cfg_opt,
    input  logic [4:0]            cfg_dummy,
    input  logic                  cfg_burst_en,
    input  logic [BLEN_BITS-1:0]  cfg_burst_m1,
    input  logic [EXT_BITS-1:0]   cfg_ext,
    input  logic                  cfg_flush,
    input  logic                  rd_valid,
    input  logic [WIN_BITS-3:0]   rd_word,
    output logic                  rd_ready,
    output logic                  rd_resp_valid,
    output logic [WORD_W-1:0]     rd_resp_data,
    output logic                  rd_resp_err,
    output logic                  fl_sel,
    output logic [2:0]            fl_phase,
    output logic                  fl_mosi,
    input  logic                  fl_miso
);
    localparam int unsigned EXT_LSB    = WIN_BITS - 1;
    localparam int unsigned FA_W       = EXT_LSB + EXT_BITS;
    localparam int unsigned WA_W       = FA_W - 2;
    localparam int unsigned LINE_WORDS = 1 << BLEN_BITS;
    localparam int unsigned IDX_W      = BLEN_BITS;
    localparam int unsigned LEN_W      = BLEN_BITS + 1;

    frame_t             frame;
    logic [WA_W-1:0]    req_wa;
    logic [LEN_W-1:0]   burst_len;
    logic [WA_W-1:0]    align_mask;
    logic [WA_W-1:0]    fill_base;
    logic [LEN_W-1:0]   fill_len;
    logic [WA_W-1:0]    look_addr;
    logic               hit;
    logic [WORD_W-1:0]  look_data;
    logic               accept;
    logic               start_fill;
    logic               seq_done;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [WORD_W-1:0]  wr_data;

    ctl_e               st_q;
    logic [WA_W-1:0]    pend_q;
    logic               keep_q;
    logic               resp_v_q;
    logic               resp_err_q;
    logic [WORD_W-1:0]  resp_data_q;

    always_comb begin
        frame.cmd_en  = cfg_cmd_en;
        frame.cmd     = cfg_cmd;
        frame.addr_en = cfg_addr_en;
        frame.addr4   = cfg_addr4;
        frame.opt_en  = cfg_opt_en;
        frame.opt     = cfg_opt;
        frame.dummy   = cfg_dummy;
    end

    // Extended bits land at flash bit 25 (word bit 23) and OR with the offset.
    assign req_wa     = {cfg_ext, {(EXT_LSB-2){1'b0}}} | WA_W'(rd_word);
    assign burst_len  = LEN_W'(cfg_burst_m1) + LEN_W'(1);
    assign align_mask = WA_W'(pow2_floor(32'(burst_len)) - 32'd1);
    assign fill_base  = cfg_burst_en ? (req_wa & ~align_mask) : req_wa;
    assign fill_len   = cfg_burst_en ? burst_len : LEN_W'(1);

    assign rd_ready   = st_q == CT_IDLE;
    assign accept     = rd_valid && rd_ready;
    assign look_addr  = (st_q == CT_FILL) ? pend_q : req_wa;
    assign start_fill = accept && !cfg_manual && !(cfg_burst_en && hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= CT_IDLE;
            pend_q      <= '0;
            keep_q      <= 1'b0;
            resp_v_q    <= 1'b0;
            resp_err_q  <= 1'b0;
            resp_data_q <= '0;
        end else begin
            resp_v_q   <= 1'b0;
            resp_err_q <= 1'b0;
            case (st_q)
                CT_IDLE: begin
                    if (accept) begin
                        if (cfg_manual) begin
                            resp_v_q    <= 1'b1;
                            resp_err_q  <= 1'b1;
                            resp_data_q <= '0;
                        end else if (cfg_burst_en && hit) begin
                            resp_v_q    <= 1'b1;
                            resp_data_q <= look_data;
                        end else begin
                            st_q   <= CT_FILL;
                            pend_q <= req_wa;
                            keep_q <= cfg_burst_en;
                        end
                    end
                end
                CT_FILL: begin
                    if (seq_done) begin
                        resp_v_q    <= 1'b1;
                        resp_data_q <= look_data;
                        st_q        <= CT_IDLE;
                    end
                end
                default: st_q <= CT_IDLE;
            endcase
        end
    end

    assign rd_resp_valid = resp_v_q;
    assign rd_resp_err   = resp_err_q;
    assign rd_resp_data  = resp_data_q;

    frw_seq #(
        .LINE_WORDS (LINE_WORDS),
        .WA_W       (WA_W)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start_fill),
        .frame    (frame),
        .waddr    (fill_base),
        .nwords   (fill_len),
        .done     (seq_done),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .fl_sel   (fl_sel),
        .fl_phase (fl_phase),
        .fl_mosi  (fl_mosi),
        .fl_miso  (fl_miso)
    );

    frw_line #(
        .LINE_WORDS (LINE_WORDS),
        .WA_W       (WA_W)
    ) line_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (cfg_flush),
        .fill_start (start_fill),
        .fill_base  (fill_base),
        .fill_len   (fill_len),
        .fill_done  (seq_done),
        .fill_keep  (keep_q),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .look_addr  (look_addr),
        .hit        (hit),
        .look_data  (look_data)
    );

endmodule

// File: rtl/flash_read_window_chk.sv
module frw_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       cfg_manual,
    input logic       rd_resp_valid,
    input logic       rd_resp_err,
    input logic       fl_sel,
    input logic [2:0] fl_phase
);

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
        fl_sel && $past(fl_sel) && (fl_phase != $past(fl_phase)) |-> fl_phase > $past(fl_phase));

    assert_phase_code_R2: assert property (@(posedge clk) disable iff (rst)
        fl_sel |-> (fl_phase != 3'd0) && (fl_phase <= 3'd5));

    assert_manual_err_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_ready && cfg_manual |=> rd_resp_valid && rd_resp_err);

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        rd_resp_err |-> rd_resp_valid && !fl_sel);

    assert_busy_stall_R10: assert property (@(posedge clk) disable iff (rst)
        fl_sel |-> !rd_ready);

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> !fl_sel && rd_ready && !rd_resp_valid);

endmodule

bind flash_read_window frw_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .cfg_manual    (cfg_manual),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_err   (rd_resp_err),
    .fl_sel        (fl_sel),
    .fl_phase      (fl_phase)
);

// File: tb/flash_read_window_tb_top.sv
module flash_read_window_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_manual = 1'b0;
    logic        cfg_cmd_en = 1'b1;
    logic [7:0]  cfg_cmd = 8'h0B;
    logic        cfg_addr_en = 1'b1;
    logic        cfg_addr4 = 1'b0;
    logic        cfg_opt_en = 1'b0;
    logic [7:0]  cfg_opt = 8'h00;
    logic [4:0]  cfg_dummy = 5'd0;
    logic        cfg_burst_en = 1'b0;
    logic [4:0]  cfg_burst_m1 = 5'd0;
    logic [3:0]  cfg_ext = 4'd0;
    logic        cfg_flush = 1'b0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_word = '0;
    logic        rd_ready;
    logic        rd_resp_valid;
    logic [31:0] rd_resp_data;
    logic        rd_resp_err;
    logic        fl_sel;
    logic [2:0]  fl_phase;
    logic        fl_mosi;
    logic        fl_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    flash_read_window dut_i (
        .clk(clk), .rst(rst), .cfg_manual(cfg_manual), .cfg_cmd_en(cfg_cmd_en),
        .cfg_cmd(cfg_cmd), .cfg_addr_en(cfg_addr_en), .cfg_addr4(cfg_addr4),
        .cfg_opt_en(cfg_opt_en), .cfg_opt(cfg_opt), .cfg_dummy(cfg_dummy),
        .cfg_burst_en(cfg_burst_en), .cfg_burst_m1(cfg_burst_m1), .cfg_ext(cfg_ext),
        .cfg_flush(cfg_flush), .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .rd_resp_err(rd_resp_err), .fl_sel(fl_sel), .fl_phase(fl_phase),
        .fl_mosi(fl_mosi), .fl_miso(fl_miso)
    );

    // Flash content: a computed byte pattern.
    function automatic logic [7:0] fbyte(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A ^ {a[2:0], 5'b0};
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] a);
        return {fbyte(a + 3), fbyte(a + 2), fbyte(a + 1), fbyte(a)};
    endfunction

    // Flash model, sampling and driving at the falling edge.
    int          txn = 0;
    int          m_cmd_n, m_addr_n, m_opt_n, m_dum_n, m_data_n;
    logic [7:0]  m_cmd, m_opt;
    logic [31:0] m_addr;
    bit          m_order_bad;
    logic        prev_sel = 1'b0;
    logic [2:0]  prev_ph = 3'd0;

    always @(negedge clk) begin
        if (fl_sel) begin
            if (!prev_sel) begin
                txn++;
                m_cmd_n = 0; m_addr_n = 0; m_opt_n = 0; m_dum_n = 0; m_data_n = 0;
                m_cmd = 0; m_opt = 0; m_addr = 0; m_order_bad = 0; prev_ph = 3'd0;
            end
            if (prev_ph != 3'd0 && fl_phase < prev_ph) m_order_bad = 1;
            case (fl_phase)
                3'd1: begin m_cmd = {m_cmd[6:0], fl_mosi}; m_cmd_n++; end
                3'd2: begin m_addr = {m_addr[30:0], fl_mosi}; m_addr_n++; end
                3'd3: begin m_opt = {m_opt[6:0], fl_mosi}; m_opt_n++; end
                3'd4: m_dum_n++;
                3'd5: begin
                    fl_miso = fbyte(m_addr + 32'(m_data_n / 8))[7 - (m_data_n % 8)];
                    m_data_n++;
                end
                default: m_order_bad = 1;
            endcase
            prev_ph = fl_phase;
        end
        prev_sel = fl_sel;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic do_read(input logic [23:0] w, output logic [31:0] d, output logic e, output int lat);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_valid = 1'b1;
        rd_word  = w;
        @(negedge clk);
        rd_valid = 1'b0;
        lat = 1;
        while (!rd_resp_valid && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        d = rd_resp_data;
        e = rd_resp_err;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        cfg_flush = 1'b1;
        @(negedge clk);
        cfg_flush = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rd_ready && !fl_sel && fl_phase == 3'd0 && !rd_resp_valid, "R11 reset state",
            {28'b0, rd_ready, fl_sel, rd_resp_valid, 1'b0}, 32'h8);
    endtask

    task automatic t_manual();
        logic [31:0] d; logic e; int lat; int t0;
        cfg_manual = 1'b1;
        t0 = txn;
        do_read(24'h10, d, e, lat);
        chk(e && lat == 1 && d == 0, "R9 manual error response", {d[29:0], e, 1'b0} ^ 32'(lat), 32'h3);
        chk(txn == t0, "R9 no flash frame in manual mode", 32'(txn), 32'(t0));
        cfg_manual = 1'b0;
    endtask

    task automatic t_frame();
        logic [31:0] d; logic e; int lat; int t0;
        cfg_cmd_en = 1; cfg_cmd = 8'h0B; cfg_addr_en = 1; cfg_addr4 = 0;
        cfg_opt_en = 1; cfg_opt = 8'hA5; cfg_dummy = 5'd8; cfg_burst_en = 0; cfg_ext = 0;
        t0 = txn;
        do_read(24'h49, d, e, lat);
        chk(txn == t0 + 1, "R2 one frame per miss", 32'(txn), 32'(t0 + 1));
        chk(m_cmd == 8'h0B && m_cmd_n == 8, "R2 opcode phase", {m_cmd, 24'(m_cmd_n)}, {8'h0B, 24'd8});
        chk(m_addr == 32'h124 && m_addr_n == 24, "R1 24-bit address phase", m_addr, 32'h124);
        chk(m_opt == 8'hA5 && m_opt_n == 8, "R2 option phase", {m_opt, 24'(m_opt_n)}, {8'hA5, 24'd8});
        chk(m_dum_n == 8 && m_data_n == 32 && !m_order_bad, "R2 dummy count, data length, order",
            32'(m_dum_n), 32'd8);
        chk(d == exp_word(32'h124) && !e, "R3 little-endian word", d, exp_word(32'h124));
        do_read(24'h49, d, e, lat);
        chk(txn == t0 + 2 && lat > 1, "R8 no buffering with bursts off", 32'(txn), 32'(t0 + 2));
        chk(d == exp_word(32'h124), "R8 refetched data", d, exp_word(32'h124));
    endtask

    task automatic t_burst();
        logic [31:0] d; logic e; int lat; int t0;
        cfg_opt_en = 0; cfg_dummy = 0; cfg_addr4 = 1;
        cfg_burst_en = 1; cfg_burst_m1 = 5'd7;
        pulse_flush();
        t0 = txn;
        do_read(24'd13, d, e, lat);
        chk(m_addr == 32'h20 && m_addr_n == 32 && m_opt_n == 0, "R4 aligned base, 32-bit address",
            m_addr, 32'h20);
        chk(m_data_n == 256, "R4 burst of eight words", 32'(m_data_n), 32'd256);
        chk(d == exp_word(32'd52), "R4 miss data", d, exp_word(32'd52));
        do_read(24'd15, d, e, lat);
        chk(lat == 1 && txn == t0 + 1, "R5 hit answered next cycle", 32'(lat), 32'd1);
        chk(d == exp_word(32'd60), "R5 hit data", d, exp_word(32'd60));
        do_read(24'd16, d, e, lat);
        chk(txn == t0 + 2 && m_addr == 32'h40, "R4 read past line misses", m_addr, 32'h40);
    endtask

    task automatic t_nonpow();
        logic [31:0] d; logic e; int lat; int t0;
        cfg_burst_m1 = 5'd5;
        pulse_flush();
        t0 = txn;
        do_read(24'd21, d, e, lat);
        chk(m_addr == 32'd80 && m_data_n == 192, "R4 six-word burst aligned to four", m_addr, 32'd80);
        do_read(24'd25, d, e, lat);
        chk(lat == 1 && d == exp_word(32'd100), "R5 hit at line end", d, exp_word(32'd100));
        do_read(24'd26, d, e, lat);
        chk(txn == t0 + 2 && m_addr == 32'd96, "R4 next line base", m_addr, 32'd96);
    endtask

    task automatic t_flush();
        logic [31:0] d; logic e; int lat; int t0;
        cfg_burst_m1 = 5'd3;
        do_read(24'd40, d, e, lat);
        t0 = txn;
        do_read(24'd41, d, e, lat);
        chk(lat == 1 && txn == t0, "R5 hit before flush", 32'(txn), 32'(t0));
        pulse_flush();
        do_read(24'd41, d, e, lat);
        chk(txn == t0 + 1 && lat > 1, "R6 flush forces refetch", 32'(txn), 32'(t0 + 1));
        chk(d == exp_word(32'd164), "R6 refetched data", d, exp_word(32'd164));
    endtask

    task automatic t_ext();
        logic [31:0] d; logic e; int lat; int t0;
        cfg_burst_m1 = 5'd3; cfg_addr4 = 1; cfg_ext = 4'd2;
        do_read(24'd4, d, e, lat);
        chk(m_addr == 32'h0400_0010, "R1 extended bits at bit 25", m_addr, 32'h0400_0010);
        chk(d == exp_word(32'h0400_0010), "R1 data with extended bits", d, exp_word(32'h0400_0010));
        t0 = txn;
        cfg_ext = 4'd3;
        do_read(24'd4, d, e, lat);
        chk(txn == t0 + 1 && m_addr == 32'h0600_0010, "R7 extended change misses", m_addr, 32'h0600_0010);
        cfg_ext = 4'd2;
        do_read(24'h80_0004, d, e, lat);
        chk(lat == 1 && txn == t0 + 1, "R1 offset bit 25 aliases extended bit", 32'(lat), 32'd1);
        chk(d == exp_word(32'h0600_0010), "R1 aliased data", d, exp_word(32'h0600_0010));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_manual();
        t_frame();
        t_burst();
        t_nonpow();
        t_flush();
        t_ext();
        t_manual();
        done = 1;
        finish_run();
    end

endmodule